// File: doc/BRIEF.md
# Predicated Halfword-Aware DSP ALU

This block is the arithmetic and logic stage of a small fixed-point signal-processing datapath. Each cycle it takes two source operands, the current destination value, an operation code, an execution mode and a condition flag. It works out the operation combinationally. When the capture strobe is high, it registers either the new value or the unchanged destination value, together with the updated flag.

Two of the operations treat a word as a fixed-point number whose integer part sits in the upper halfword. These operations step the upper half by one and zero the lower half. The AND operation also acts only on the upper halves. Every operation can be predicated. It can run always, only while the flag is set, only while the flag is clear, or never. A suppressed operation writes back the old destination value and leaves the flag alone. Operand selection, register storage and the multiplier sit outside this block.

Top module: `dsp_pred_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `result` and `flag_q` become 0.
- R2: Opcode 0 (add) produces `src_a + src_b` modulo 2^32, so 0xA5A5A5A5 + 0xA5A5A5A5 gives 0x4B4B4B4A.
- R3: Opcode 1 (add with carry) produces `src_a + src_b + flag_in` modulo 2^32, so 2 + 2 gives 4 with the flag clear and 5 with the flag set.
- R4: Opcode 3 (increment) produces the upper halfword of `src_a` plus one, wrapping within 16 bits, with the lower halfword zero. So 0xA5A5A5A5 gives 0xA5A60000 and 0xFFFF1234 gives 0.
- R5: Opcode 4 (decrement) produces the upper halfword of `src_a` minus one, wrapping within 16 bits, with the lower halfword zero. So 0xA5A5A5A5 gives 0xA5A40000 and 0x00001234 gives 0xFFFF0000.
- R6: Opcode 2 (AND) produces the AND of the two upper halfwords in the upper half and zero in the lower half. So 0xA5A5A5A5 AND 0xA5A5A5A5 gives 0xA5A50000.
- R7: Mode 0 always executes. Mode 1 executes only when `flag_in` is 1. Mode 2 executes only when `flag_in` is 0. Mode 3 never executes. A captured operation that does not execute stores `dst_old` in `result`.
- R8: An add with carry in mode 0 loads `flag_q` with the carry out of bit 31. In every other captured case, `flag_q` loads `flag_in` unchanged. This includes a conditional add with carry that produces a carry.
- R9: While `en` is low, `result` and `flag_q` hold their values whatever the other inputs do.
- R10: Opcodes 5 to 7 are reserved and act as a suppressed operation: `result` takes `dst_old` and `flag_q` takes `flag_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Capture strobe for result and flag |
| op | input | 3 | Operation code (0 add, 1 add with carry, 2 AND, 3 increment, 4 decrement) |
| cmode | input | 2 | Execution mode (0 always, 1 if flag set, 2 if flag clear, 3 never) |
| flag_in | input | 1 | Condition flag, also used as the carry-in |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| dst_old | input | 32 | Current destination value, kept when the operation is suppressed |
| result | output | 32 | Registered result |
| flag_q | output | 1 | Registered updated flag |

## Verification
Carry generation and predicate suppression can meet in one capture. An add with carry whose sum overflows bit 31 is issued under a mode that lets it execute, so the carry out exists but must not reach the flag. The bench drives 0xFFFFFFFF + 1 in the "if clear" mode with the flag at 0. It expects a result of 0 and a flag that stays 0. It then compares that case with the same sum in mode 0, where the flag must rise to 1.

// File: rtl/pred_alu_pkg.sv
package pred_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDC = 3'd1,
        OP_AND  = 3'd2,
        OP_INC  = 3'd3,
        OP_DEC  = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        CM_ALWAYS = 2'd0,
        CM_IF_SET = 2'd1,
        CM_IF_CLR = 2'd2,
        CM_NEVER  = 2'd3
    } cmode_e;

    typedef struct packed {
        logic known;
        logic carry_out;
        logic carry_op;
    } core_info_t;

    function automatic logic pred_pass(input cmode_e m, input logic f);
        case (m)
            CM_ALWAYS: return 1'b1;
            CM_IF_SET: return f;
            CM_IF_CLR: return ~f;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/alu_core.sv
module alu_core
    import pred_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2:0]   op,
    input  logic         cin,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output core_info_t   info
);
    localparam int H = W / 2;

    logic [W:0]   full_sum;
    logic [H-1:0] hi_inc;
    logic [H-1:0] hi_dec;
    logic [H-1:0] hi_and;
    alu_op_e      op_e;

    assign op_e     = alu_op_e'(op);
    assign full_sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin & (op_e == OP_ADDC)};
    assign hi_inc   = a[W-1:H] + {{(H-1){1'b0}}, 1'b1};
    assign hi_dec   = a[W-1:H] - {{(H-1){1'b0}}, 1'b1};
    assign hi_and   = a[W-1:H] & b[W-1:H];

    always_comb begin
        info.known     = 1'b1;
        info.carry_out = full_sum[W];
        info.carry_op  = 1'b0;
        res            = '0;
        case (op_e)
            OP_ADD:  res = full_sum[W-1:0];
            OP_ADDC: begin
                res           = full_sum[W-1:0];
                info.carry_op = 1'b1;
            end
            OP_AND:  res = {hi_and, {H{1'b0}}};
            OP_INC:  res = {hi_inc, {H{1'b0}}};
            OP_DEC:  res = {hi_dec, {H{1'b0}}};
            default: info.known = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_gate.sv
module alu_gate
    import pred_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]   cmode,
    input  logic         flag_in,
    input  core_info_t   info,
    input  logic [W-1:0] core_res,
    input  logic [W-1:0] dst_old,
    output logic [W-1:0] next_res,
    output logic         next_flag
);
    cmode_e mode_e;
    logic   fire;

    assign mode_e = cmode_e'(cmode);
    assign fire   = pred_pass(mode_e, flag_in) & info.known;

    always_comb begin
        next_res  = fire ? core_res : dst_old;
        next_flag = flag_in;
        if (fire && info.carry_op && mode_e == CM_ALWAYS)
            next_flag = info.carry_out;
    end
endmodule

// File: rtl/dsp_pred_alu.sv
module dsp_pred_alu
    import pred_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [2:0]   op,
    input  logic [1:0]   cmode,
    input  logic         flag_in,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    input  logic [W-1:0] dst_old,
    output logic [W-1:0] result,
    output logic         flag_q
);
    logic [W-1:0] core_res;
    core_info_t   info;
    logic [W-1:0] next_res;
    logic         next_flag;

    alu_core #(.W(W)) u_core (
        .op(op), .cin(flag_in), .a(src_a), .b(src_b),
        .res(core_res), .info(info)
    );

    alu_gate #(.W(W)) u_gate (
        .cmode(cmode), .flag_in(flag_in), .info(info),
        .core_res(core_res), .dst_old(dst_old),
        .next_res(next_res), .next_flag(next_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            flag_q <= 1'b0;
        end else if (en) begin
            result <= next_res;
            flag_q <= next_flag;
        end
    end
endmodule

// File: rtl/alu_chk.sv
module alu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic [2:0]   op,
    input logic [1:0]   cmode,
    input logic         flag_in,
    input logic [W-1:0] dst_old,
    input logic [W-1:0] result,
    input logic         flag_q
);
    localparam int H = W / 2;

    logic runs;
    assign runs = (cmode == 2'd0) || (cmode == 2'd1 && flag_in) || (cmode == 2'd2 && !flag_in);

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(result) && $stable(flag_q)));

    a_r7_suppressed_keeps_dst: assert property (@(posedge clk) disable iff (rst)
        (en && !runs) |=> (result == $past(dst_old)));

    a_r8_cond_flag_passthru: assert property (@(posedge clk) disable iff (rst)
        (en && cmode != 2'd0) |=> (flag_q == $past(flag_in)));

    a_r4_inc_low_zero: assert property (@(posedge clk) disable iff (rst)
        (en && runs && (op == 3'd3 || op == 3'd4 || op == 3'd2)) |=> (result[H-1:0] == '0));

    a_r10_reserved_keeps: assert property (@(posedge clk) disable iff (rst)
        (en && op > 3'd4) |=> (result == $past(dst_old) && flag_q == $past(flag_in)));
endmodule

bind dsp_pred_alu alu_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .en(en), .op(op), .cmode(cmode), .flag_in(flag_in),
    .dst_old(dst_old), .result(result), .flag_q(flag_q)
);

// File: tb/sim_dsp_pred_alu.sv
module sim_dsp_pred_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  cmode = '0;
    logic        flag_in = 1'b0;
    logic [31:0] src_a = '0, src_b = '0, dst_old = '0;
    logic [31:0] result;
    logic        flag_q;
    int          n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    dsp_pred_alu u0 (
        .clk(clk), .rst(rst), .en(en), .op(op), .cmode(cmode), .flag_in(flag_in),
        .src_a(src_a), .src_b(src_b), .dst_old(dst_old), .result(result), .flag_q(flag_q)
    );

    task automatic check(input string req, input logic [31:0] er, input logic ef);
        n_chk++;
        if (result !== er || flag_q !== ef) begin
            n_bad++;
            $display("FAIL %s: result=%h flag=%b expected result=%h flag=%b", req, result, flag_q, er, ef);
        end
    endtask

    task automatic issue(input logic [2:0] o, input logic [1:0] m, input logic f,
                         input logic [31:0] a, input logic [31:0] b, input logic [31:0] d);
        @(negedge clk);
        op = o; cmode = m; flag_in = f; src_a = a; src_b = b; dst_old = d; en = 1'b1;
        @(posedge clk);
        #1;
        en = 1'b0;
    endtask

    task automatic t_reset;
        check("R1", 32'h0, 1'b0);
    endtask

    task automatic t_add;
        issue(3'd0, 2'd0, 1'b0, 32'hA5A5A5A5, 32'hA5A5A5A5, 32'h0);
        check("R2", 32'h4B4B4B4A, 1'b0);
        issue(3'd0, 2'd0, 1'b1, 32'd2, 32'd2, 32'h0);
        check("R2", 32'd4, 1'b1);
    endtask

    task automatic t_addc;
        issue(3'd1, 2'd0, 1'b0, 32'd2, 32'd2, 32'h0);
        check("R3", 32'd4, 1'b0);
        issue(3'd1, 2'd0, 1'b1, 32'd2, 32'd2, 32'h0);
        check("R3", 32'd5, 1'b0);
        issue(3'd1, 2'd0, 1'b0, 32'hFFFFFFFF, 32'd1, 32'h0);
        check("R8", 32'd0, 1'b1);
        issue(3'd1, 2'd2, 1'b0, 32'hFFFFFFFF, 32'd1, 32'h0);
        check("R8", 32'd0, 1'b0);
    endtask

    task automatic t_half;
        issue(3'd3, 2'd0, 1'b0, 32'hA5A5A5A5, 32'h0, 32'h0);
        check("R4", 32'hA5A60000, 1'b0);
        issue(3'd3, 2'd0, 1'b0, 32'hFFFF1234, 32'h0, 32'h1);
        check("R4", 32'h0, 1'b0);
        issue(3'd4, 2'd0, 1'b0, 32'hA5A5A5A5, 32'h0, 32'h0);
        check("R5", 32'hA5A40000, 1'b0);
        issue(3'd4, 2'd0, 1'b0, 32'h00001234, 32'h0, 32'h0);
        check("R5", 32'hFFFF0000, 1'b0);
        issue(3'd2, 2'd0, 1'b0, 32'hA5A5A5A5, 32'hA5A5A5A5, 32'h0);
        check("R6", 32'hA5A50000, 1'b0);
        issue(3'd2, 2'd0, 1'b0, 32'h5A5A5A5A, 32'hA5A5A5A5, 32'h1);
        check("R6", 32'h0, 1'b0);
    endtask

    task automatic t_pred;
        issue(3'd0, 2'd1, 1'b0, 32'd2, 32'd2, 32'hA5A5A5A5);
        check("R7", 32'hA5A5A5A5, 1'b0);
        issue(3'd0, 2'd1, 1'b1, 32'd2, 32'd2, 32'hA5A5A5A5);
        check("R7", 32'd4, 1'b1);
        issue(3'd3, 2'd2, 1'b1, 32'hA5A5A5A5, 32'h0, 32'h12345678);
        check("R7", 32'h12345678, 1'b1);
        issue(3'd3, 2'd2, 1'b0, 32'hA5A5A5A5, 32'h0, 32'h12345678);
        check("R7", 32'hA5A60000, 1'b0);
        issue(3'd0, 2'd3, 1'b1, 32'd2, 32'd2, 32'hCAFE0001);
        check("R7", 32'hCAFE0001, 1'b1);
    endtask

    task automatic t_hold_reserved;
        issue(3'd0, 2'd0, 1'b1, 32'd7, 32'd8, 32'h0);
        check("R9", 32'd15, 1'b1);
        @(negedge clk);
        op = 3'd1; cmode = 2'd0; flag_in = 1'b0; src_a = 32'hFFFFFFFF; src_b = 32'd5;
        @(posedge clk); #1;
        @(posedge clk); #1;
        check("R9", 32'd15, 1'b1);
        issue(3'd5, 2'd0, 1'b0, 32'd1, 32'd1, 32'hDEAD0000);
        check("R10", 32'hDEAD0000, 1'b0);
        issue(3'd7, 2'd0, 1'b1, 32'd1, 32'd1, 32'h0000BEEF);
        check("R10", 32'h0000BEEF, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_add();
        t_addc();
        t_half();
        t_pred();
        t_hold_reserved();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule